// File: doc/BRIEF.md
# FIFO-Occupancy Latency Allowance Scaler

This block sits next to one memory client's FIFO and produces the latency allowance that the memory arbiter applies to that client. Software programs a base allowance, three free-space percentages, a per-client flag that permits scaling, and requests or releases a shared scaling enable through a reference count. While scaling is active, the block watches how much of the FIFO is free. It lowers the allowance in four fixed steps as the FIFO drains: the full value, half of it, a quarter of it, or zero. Zero is the most urgent value the arbiter can see.

The free space is turned into a percentage of the FIFO depth and then scaled by the base allowance. This puts it in the same units as the thresholds, which are also scaled by the allowance. All scaling uses truncating integer arithmetic. The thresholds are always derived from the allowance currently held, so a new allowance takes effect on the band boundaries immediately.

Top module: `la_fifo_scaler`

## Requirements
- R1: With scaling active, a free level at or below the low threshold gives the full base allowance. The free level is floor(floor(free*100/DEPTH)*allowance/100).
- R2: With scaling active, a free level above the low threshold and at or below the mid threshold gives the allowance shifted right by one.
- R3: With scaling active, a free level above the mid threshold and at or below the high threshold gives the allowance shifted right by two.
- R4: With scaling active, a free level above the high threshold gives zero.
- R5: Each threshold equals floor(percent*allowance/100), using the allowance currently held. A FIFO free count above DEPTH is treated as DEPTH.
- R6: Register 3 holds the scaling reference count. Writing bit0=1 with bit1=0 increments it, and writing bit1=1 with bit0=0 decrements it. A decrement at zero and an increment at the maximum are ignored. Scaling is active whenever the count is non-zero. A read returns the count in bits [CNT_W-1:0] and the active flag in bit 16.
- R7: When the support flag (register 2, bit0) is clear, the output is the base allowance regardless of the free space.
- R8: Register 1 holds the low, mid and high percentages in bits [7:0], [15:8] and [23:16]. A write is accepted only if low ≤ mid ≤ high ≤ 100. Otherwise all three keep their previous values.
- R9: After reset, the allowance (register 0, bits [LA_W-1:0]) is RST_LA, all three percentages are 100, the support flag is 0, the count is 0, and the output equals RST_LA.
- R10: The output is registered. A change of free space or of any setting appears on the output one clock after it is presented. With scaling inactive, the output equals the allowance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| fifo_free | input | FREE_W | Current number of free FIFO entries |
| la_out | output | LA_W | Latency allowance presented to the arbiter |

## Verification
A wrong reference count or support flag shows up as an output that stays at the full allowance when the FIFO is empty, or drops to zero when it should not. This is visible one clock after the free count changes. A corrupted percentage or a bad threshold computation moves a band edge. For that reason the stimulus places free counts on both sides of each edge, for several allowances, where truncation lands the free level exactly on a threshold. A rejected threshold write that leaks through would show in the register readback on the very next read.

// File: rtl/la_fifo_scaler.sv
module la_fifo_scaler #(
  parameter int LA_W   = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 4,
  parameter int RST_LA = 150,
  parameter int FREE_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [FREE_W-1:0] fifo_free,
  output logic [LA_W-1:0]   la_out
);
  localparam int MW = LA_W + 8;
  localparam int FW = FREE_W + 8;
  localparam logic [MW-1:0] HUNDRED_M = MW'(100);
  localparam logic [FW-1:0] HUNDRED_F = FW'(100);
  localparam logic [FW-1:0] DEPTH_F   = FW'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LA_W-1:0]  la_reg;
  logic [7:0]       pct_lo, pct_mid, pct_hi;
  logic             support;
  logic [CNT_W-1:0] cnt;
  logic             scale_en;

  logic [7:0] w_lo, w_mid, w_hi;
  logic       thr_ok, acq, rel;

  assign w_lo   = reg_wdata[7:0];
  assign w_mid  = reg_wdata[15:8];
  assign w_hi   = reg_wdata[23:16];
  assign thr_ok = (w_lo <= w_mid) && (w_mid <= w_hi) && (w_hi <= 8'd100);
  assign acq    = reg_wr && reg_addr == 2'd3 && reg_wdata[0] && !reg_wdata[1];
  assign rel    = reg_wr && reg_addr == 2'd3 && reg_wdata[1] && !reg_wdata[0];
  assign scale_en = |cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      la_reg  <= LA_W'(RST_LA);
      pct_lo  <= 8'd100;
      pct_mid <= 8'd100;
      pct_hi  <= 8'd100;
      support <= 1'b0;
      cnt     <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) la_reg <= reg_wdata[LA_W-1:0];
      if (reg_wr && reg_addr == 2'd1 && thr_ok) begin
        pct_lo  <= w_lo;
        pct_mid <= w_mid;
        pct_hi  <= w_hi;
      end
      if (reg_wr && reg_addr == 2'd2) support <= reg_wdata[0];
      if (acq && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      else if (rel && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      2'd0: reg_rdata = 32'(la_reg);
      2'd1: reg_rdata = {8'd0, pct_hi, pct_mid, pct_lo};
      2'd2: reg_rdata = {31'd0, support};
      default: reg_rdata = {15'd0, scale_en, 16'(cnt)};
    endcase
  end

  logic [FREE_W-1:0] free_c;
  logic [FW-1:0]     free_prod;
  logic [7:0]        free_pct;
  logic [MW-1:0]     lvl, t_lo, t_mid, t_hi;

  assign free_c    = (32'(fifo_free) > DEPTH) ? FREE_W'(DEPTH) : fifo_free;
  assign free_prod = (FW'(free_c) * HUNDRED_F) / DEPTH_F;
  assign free_pct  = free_prod[7:0];
  assign lvl   = (MW'(free_pct) * MW'(la_reg)) / HUNDRED_M;
  assign t_lo  = (MW'(pct_lo)   * MW'(la_reg)) / HUNDRED_M;
  assign t_mid = (MW'(pct_mid)  * MW'(la_reg)) / HUNDRED_M;
  assign t_hi  = (MW'(pct_hi)   * MW'(la_reg)) / HUNDRED_M;

  logic [LA_W-1:0] la_nxt;
  always_comb begin
    if (!scale_en || !support) la_nxt = la_reg;
    else if (lvl <= t_lo)      la_nxt = la_reg;
    else if (lvl <= t_mid)     la_nxt = la_reg >> 1;
    else if (lvl <= t_hi)      la_nxt = la_reg >> 2;
    else                       la_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) la_out <= LA_W'(RST_LA);
    else        la_out <= la_nxt;
  end
endmodule

// File: rtl/la_fifo_scaler_chk.sv
module la_fifo_scaler_chk #(
  parameter int LA_W  = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LA_W-1:0]  la_out,
  input logic [LA_W-1:0]  la_reg,
  input logic             scale_en,
  input logic             support,
  input logic [7:0]       pct_lo,
  input logic [7:0]       pct_mid,
  input logic [7:0]       pct_hi,
  input logic [CNT_W-1:0] cnt
);
  AST_BYPASS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!scale_en || !support) |=> la_out == $past(la_reg)); // R7

  AST_STEP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (la_out == $past(la_reg) || la_out == ($past(la_reg) >> 1) ||
               la_out == ($past(la_reg) >> 2) || la_out == '0)); // R1

  AST_PCT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    pct_lo <= pct_mid && pct_mid <= pct_hi && pct_hi <= 8'd100); // R8

  AST_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scale_en) |-> $past(cnt) == '0); // R6

  AST_EN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scale_en) |-> $past(cnt) == CNT_W'(1)); // R6
endmodule

bind la_fifo_scaler la_fifo_scaler_chk #(.LA_W(LA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .la_out(la_out), .la_reg(la_reg),
  .scale_en(scale_en), .support(support), .pct_lo(pct_lo),
  .pct_mid(pct_mid), .pct_hi(pct_hi), .cnt(cnt)
);

// File: tb/la_fifo_scaler_tb.sv
module la_fifo_scaler_tb;
  localparam int LA_W = 8;
  localparam int DEPTH = 64;
  localparam int FREE_W = $clog2(DEPTH + 1);
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [FREE_W-1:0] fifo_free = '0;
  logic [LA_W-1:0] la_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  la_fifo_scaler u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_free(fifo_free),
    .la_out(la_out)
  );

  // {allowance, low%, mid%, high%, free, band: 0 full,1 half,2 quarter,3 zero}
  localparam logic [41:0] VEC [NV] = '{
    {8'd200, 8'd20, 8'd50, 8'd80, 8'd0,  2'd0},
    {8'd200, 8'd20, 8'd50, 8'd80, 8'd12, 2'd0},
    {8'd200, 8'd20, 8'd50, 8'd80, 8'd13, 2'd0},
    {8'd200, 8'd20, 8'd50, 8'd80, 8'd14, 2'd1},
    {8'd200, 8'd20, 8'd50, 8'd80, 8'd32, 2'd1},
    {8'd200, 8'd20, 8'd50, 8'd80, 8'd33, 2'd2},
    {8'd200, 8'd20, 8'd50, 8'd80, 8'd51, 2'd2},
    {8'd200, 8'd20, 8'd50, 8'd80, 8'd52, 2'd3},
    {8'd200, 8'd20, 8'd50, 8'd80, 8'd64, 2'd3},
    {8'd100, 8'd10, 8'd10, 8'd90, 8'd6,  2'd0},
    {8'd100, 8'd10, 8'd10, 8'd90, 8'd7,  2'd0},
    {8'd100, 8'd10, 8'd10, 8'd90, 8'd8,  2'd2},
    {8'd100, 8'd10, 8'd10, 8'd90, 8'd58, 2'd2},
    {8'd100, 8'd10, 8'd10, 8'd90, 8'd59, 2'd3},
    {8'd7,   8'd30, 8'd60, 8'd90, 8'd19, 2'd0},
    {8'd7,   8'd30, 8'd60, 8'd90, 8'd28, 2'd1},
    {8'd7,   8'd30, 8'd60, 8'd90, 8'd40, 2'd1},
    {8'd7,   8'd30, 8'd60, 8'd90, 8'd46, 2'd1},
    {8'd7,   8'd30, 8'd60, 8'd90, 8'd47, 2'd2},
    {8'd7,   8'd30, 8'd60, 8'd90, 8'd61, 2'd2},
    {8'd7,   8'd30, 8'd60, 8'd90, 8'd64, 2'd3}
  };
  localparam string BAND_TAG [4] = '{"R1", "R2", "R3", "R4"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 output", 32'(la_out), 32'd150);
    rd(2'd0, r); check("R9 allowance", r, 32'd150);
    rd(2'd1, r); check("R9 percents", r, 32'h00646464);
    rd(2'd2, r); check("R9 support", r, 32'd0);
    rd(2'd3, r); check("R9 count", r, 32'd0);

    wr(2'd3, 32'd2);
    rd(2'd3, r); check("R6 release at zero", r, 32'd0);
    wr(2'd3, 32'd1);
    wr(2'd3, 32'd1);
    wr(2'd3, 32'd3);
    rd(2'd3, r); check("R6 two acquires", r, 32'h00010002);
    wr(2'd2, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] la, lo, mid, hi, fr;
      logic [1:0] band;
      logic [7:0] exp;
      {la, lo, mid, hi, fr, band} = VEC[i];
      wr(2'd0, 32'(la));
      wr(2'd1, {8'd0, hi, mid, lo});
      fifo_free = FREE_W'(fr);
      settle();
      case (band)
        2'd0: exp = la;
        2'd1: exp = la >> 1;
        2'd2: exp = la >> 2;
        default: exp = 8'd0;
      endcase
      check({BAND_TAG[band], " R5 vector"}, 32'(la_out), 32'(exp));
    end

    wr(2'd1, {8'd0, 8'd80, 8'd50, 8'd60});
    rd(2'd1, r); check("R8 order violation rejected", r, 32'h005a3c1e);
    wr(2'd1, {8'd0, 8'd101, 8'd20, 8'd10});
    rd(2'd1, r); check("R8 above 100 rejected", r, 32'h005a3c1e);
    wr(2'd1, {8'd0, 8'd100, 8'd100, 8'd100});
    rd(2'd1, r); check("R8 equal values accepted", r, 32'h00646464);

    wr(2'd0, 32'd200);
    wr(2'd1, {8'd0, 8'd80, 8'd50, 8'd20});
    fifo_free = '0;
    settle();
    check("R10 steady full", 32'(la_out), 32'd200);
    fifo_free = FREE_W'(64);
    #1;
    check("R10 no change before edge", 32'(la_out), 32'd200);
    @(negedge clk);
    check("R10 one cycle later", 32'(la_out), 32'd0);

    wr(2'd2, 32'd0);
    settle();
    check("R7 support clear", 32'(la_out), 32'd200);
    wr(2'd2, 32'd1);
    settle();
    check("R7 support set again", 32'(la_out), 32'd0);

    wr(2'd3, 32'd2);
    settle();
    check("R6 one holder left", 32'(la_out), 32'd0);
    wr(2'd3, 32'd2);
    settle();
    check("R6 R10 disabled gives allowance", 32'(la_out), 32'd200);
    rd(2'd3, r); check("R6 count back to zero", r, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule